// File: doc/BRIEF.md
# Two-Channel DMA Engine

This block moves data between memory and I/O locations without processor involvement. Two independent channels each hold a source address, a destination address, a transfer count, a transfer size, a trigger source and a bus-hold mode. Every transfer is a read from the source followed by a write of the same data to the destination. Transfers travel over one request/grant bus that the engine owns while its bus request is granted.

A channel is loaded and armed by a one-cycle start pulse, which captures its configuration inputs. A software-triggered channel begins after a trigger pulse and then runs to the end of its count. An externally triggered channel moves one item each time its device raises a request. The engine answers each such transfer with a clear strobe so that the device drops the request. A terminal-count signal marks the final transfer, and masked interrupt outputs report completion and configuration errors per channel. When both channels are ready at once, a mode input selects either a fixed order or round-robin service.

Top module: `dma2ch`

## Requirements
- R1: After reset, bus_req_o, mem_req_o, tc_o, dreq_clr_o, irq_done_o and irq_err_o are all low.
- R2: Each transfer issues one read at the source address (mem_we_o low) and then one write at the destination address (mem_we_o high) that carries the data returned by the read. mem_size_o gives the transfer size: 0 byte, 1 half-word, 2 word.
- R3: After each transfer, the source and destination addresses both advance by the transfer size in bytes (1, 2 or 4).
- R4: A programmed count N in 1..2^CNT_W-1 performs exactly N transfers. A count of 0 performs 2^CNT_W transfers.
- R5: In cycle-steal mode (cfg_burst_i low), bus_req_o goes low after every transfer, so each transfer gets its own rising edge of bus_req_o.
- R6: In burst mode (cfg_burst_i high), bus_req_o rises once and stays high until the write of the last transfer is acknowledged.
- R7: With rr_mode_i low, channel 0 wins whenever both channels are ready in the same cycle.
- R8: With rr_mode_i high, the channel served last loses the next tie. After reset, channel 0 wins the first tie.
- R9: A software-triggered channel moves nothing until sw_req_i pulses while the channel is armed. A sw_req_i pulse given while the channel is not armed is ignored.
- R10: An external-trigger channel (cfg_ext_i high) starts a cycle-steal transfer only while its dreq_i is high. Its dreq_clr_o bit is high for exactly the one cycle after each of its writes is acknowledged.
- R11: tc_o[c] is high only while channel c is performing its last transfer, from that transfer's read request until its write acknowledge. At most one bit of tc_o is high at a time.
- R12: irq_done_o[c] goes high when channel c finishes its count, and irq_err_o[c] goes high when channel c has a configuration error. Both are gated low by irq_mask_i[c], and both are cleared by the next start of that channel.
- R13: A start with a source or destination address misaligned for the size, or with size code 3, raises the error flag and produces no bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rr_mode_i | input | 1 | 1 = round-robin, 0 = fixed priority |
| start_i | input | 2 | Per-channel load-and-arm pulse |
| cfg_src_i | input | 2x AW | Source start address per channel |
| cfg_dst_i | input | 2x AW | Destination start address per channel |
| cfg_cnt_i | input | 2x CNT_W | Transfer count per channel (0 = 2^CNT_W) |
| cfg_size_i | input | 2x2 | Size code per channel |
| cfg_ext_i | input | 2 | 1 = external trigger, 0 = software trigger |
| cfg_burst_i | input | 2 | 1 = burst hold, 0 = cycle steal |
| sw_req_i | input | 2 | Software trigger pulse |
| irq_mask_i | input | 2 | Interrupt mask per channel |
| dreq_i | input | 2 | External device request |
| dreq_clr_o | output | 2 | Request clear strobe to the device |
| tc_o | output | 2 | Last transfer in progress |
| irq_done_o | output | 2 | Masked completion interrupt |
| irq_err_o | output | 2 | Masked error interrupt |
| bus_req_o | output | 1 | Bus ownership request |
| bus_gnt_i | input | 1 | Bus grant |
| mem_req_o | output | 1 | Access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_size_o | output | 2 | Size code of the access |
| mem_addr_o | output | AW | Access address |
| mem_wdata_o | output | DW | Write data |
| mem_rdata_i | input | DW | Read data, valid with ack |
| mem_ack_i | input | 1 | Access acknowledge |

## Verification
The case that needs the most care is two channels becoming ready in the same cycle, where arbitration decides the bus order. The bench starts and triggers both channels on the same clock edge in cycle-steal mode, once with fixed priority and once with round-robin. It judges the result by the order of destination writes against a queue built from the priority rules: 0,0,1,1 for fixed priority and 0,1,0,1 for round-robin. The terminal-count bit expected on each write is checked in the same comparison.

// File: rtl/dma2ch_pkg.sv
package dma2ch_pkg;
  localparam int NUM_CH = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_BUS, ST_RD, ST_WR, ST_REL
  } eng_state_e;

  // size codes: 0 byte, 1 half-word, 2 word, 3 reserved
  function automatic logic addr_ok(input logic [1:0] sz, input logic [1:0] lsb);
    case (sz)
      2'd0:    return 1'b1;
      2'd1:    return ~lsb[0];
      2'd2:    return lsb == 2'b00;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/dma2ch_chan.sv
module dma2ch_chan
  import dma2ch_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [AW-1:0]    src_i,
  input  logic [AW-1:0]    dst_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [1:0]       size_i,
  input  logic             ext_i,
  input  logic             burst_i,
  input  logic             sw_req_i,
  input  logic             dreq_i,
  input  logic             step_i,
  output logic             elig_o,
  output logic [AW-1:0]    src_o,
  output logic [AW-1:0]    dst_o,
  output logic [1:0]       size_o,
  output logic             ext_o,
  output logic             burst_o,
  output logic             last_o,
  output logic             done_o,
  output logic             err_o
);
  localparam int REM_W = CNT_W + 1;

  logic             armed_q, sw_pend_q, done_q, err_q, ext_q, burst_q;
  logic [REM_W-1:0] rem_q;
  logic [AW-1:0]    src_q, dst_q, inc;
  logic [1:0]       size_q;
  logic             cfg_ok;

  assign inc    = AW'(1) << size_q;
  assign cfg_ok = addr_ok(size_i, src_i[1:0]) && addr_ok(size_i, dst_i[1:0]);
  assign last_o = (rem_q == REM_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q   <= 1'b0;
      sw_pend_q <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      ext_q     <= 1'b0;
      burst_q   <= 1'b0;
      rem_q     <= '0;
      src_q     <= '0;
      dst_q     <= '0;
      size_q    <= '0;
    end else if (start_i) begin
      done_q    <= 1'b0;
      sw_pend_q <= 1'b0;
      armed_q   <= cfg_ok;
      err_q     <= ~cfg_ok;
      src_q     <= src_i;
      dst_q     <= dst_i;
      size_q    <= size_i;
      ext_q     <= ext_i;
      burst_q   <= burst_i;
      rem_q     <= (cnt_i == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, cnt_i};
    end else if (step_i) begin
      src_q <= src_q + inc;
      dst_q <= dst_q + inc;
      rem_q <= rem_q - REM_W'(1);
      if (last_o) begin
        armed_q   <= 1'b0;
        sw_pend_q <= 1'b0;
        done_q    <= 1'b1;
      end
    end else if (sw_req_i && armed_q && !ext_q) begin
      sw_pend_q <= 1'b1;
    end
  end

  assign elig_o  = armed_q && (ext_q ? dreq_i : sw_pend_q);
  assign src_o   = src_q;
  assign dst_o   = dst_q;
  assign size_o  = size_q;
  assign ext_o   = ext_q;
  assign burst_o = burst_q;
  assign done_o  = done_q;
  assign err_o   = err_q;
endmodule

// File: rtl/dma2ch_arb.sv
module dma2ch_arb
  import dma2ch_pkg::*;
#(
  parameter int IW = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rr_i,
  input  logic [NUM_CH-1:0] req_i,
  input  logic              upd_i,
  input  logic [IW-1:0]     served_i,
  output logic [IW-1:0]     pick_o,
  output logic              any_o
);
  logic [IW-1:0] last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    last_q <= IW'(NUM_CH - 1);
    else if (upd_i) last_q <= served_i;
  end

  // fixed: lowest index first; round-robin: search starts after last served
  always_comb begin
    int  idx;
    logic found;
    pick_o = '0;
    found  = 1'b0;
    for (int k = 0; k < NUM_CH; k++) begin
      idx = rr_i ? ((int'(last_q) + 1 + k) % NUM_CH) : k;
      if (!found && req_i[idx]) begin
        pick_o = IW'(idx);
        found  = 1'b1;
      end
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/dma2ch_xfer.sv
module dma2ch_xfer
  import dma2ch_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int IW = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          any_i,
  input  logic [IW-1:0] pick_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic [1:0]    size_i,
  input  logic          burst_i,
  input  logic          last_i,
  input  logic          bus_gnt_i,
  input  logic [DW-1:0] rdata_i,
  input  logic          ack_i,
  output logic [IW-1:0] cur_ch_o,
  output logic          step_o,
  output logic          bus_req_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [1:0]    mem_size_o,
  output logic [DW-1:0] mem_wdata_o
);
  eng_state_e    state_q;
  logic [IW-1:0] cur_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      data_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (any_i) begin
          cur_q   <= pick_i;
          state_q <= ST_BUS;
        end
        ST_BUS: if (bus_gnt_i) state_q <= ST_RD;
        ST_RD: if (ack_i) begin
          data_q  <= rdata_i;
          state_q <= ST_WR;
        end
        ST_WR: if (ack_i) state_q <= (burst_i && !last_i) ? ST_RD : ST_REL;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign step_o      = (state_q == ST_WR) && ack_i;
  assign bus_req_o   = (state_q == ST_BUS) || (state_q == ST_RD) || (state_q == ST_WR);
  assign mem_req_o   = (state_q == ST_RD) || (state_q == ST_WR);
  assign mem_we_o    = (state_q == ST_WR);
  assign mem_addr_o  = (state_q == ST_WR) ? dst_i : src_i;
  assign mem_size_o  = size_i;
  assign mem_wdata_o = data_q;
  assign cur_ch_o    = cur_q;
endmodule

// File: rtl/dma2ch.sv
module dma2ch
  import dma2ch_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int CNT_W = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          rr_mode_i,
  input  logic [NUM_CH-1:0]             start_i,
  input  logic [NUM_CH-1:0][AW-1:0]     cfg_src_i,
  input  logic [NUM_CH-1:0][AW-1:0]     cfg_dst_i,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  cfg_cnt_i,
  input  logic [NUM_CH-1:0][1:0]        cfg_size_i,
  input  logic [NUM_CH-1:0]             cfg_ext_i,
  input  logic [NUM_CH-1:0]             cfg_burst_i,
  input  logic [NUM_CH-1:0]             sw_req_i,
  input  logic [NUM_CH-1:0]             irq_mask_i,
  input  logic [NUM_CH-1:0]             dreq_i,
  output logic [NUM_CH-1:0]             dreq_clr_o,
  output logic [NUM_CH-1:0]             tc_o,
  output logic [NUM_CH-1:0]             irq_done_o,
  output logic [NUM_CH-1:0]             irq_err_o,
  output logic                          bus_req_o,
  input  logic                          bus_gnt_i,
  output logic                          mem_req_o,
  output logic                          mem_we_o,
  output logic [1:0]                    mem_size_o,
  output logic [AW-1:0]                 mem_addr_o,
  output logic [DW-1:0]                 mem_wdata_o,
  input  logic [DW-1:0]                 mem_rdata_i,
  input  logic                          mem_ack_i
);
  localparam int IW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [NUM_CH-1:0] elig, ch_ext, ch_burst, ch_last, ch_done, ch_err, cur_oh;
  logic [AW-1:0]     ch_src [NUM_CH];
  logic [AW-1:0]     ch_dst [NUM_CH];
  logic [1:0]        ch_size [NUM_CH];
  logic [IW-1:0]     cur_ch, pick;
  logic              any_req, step;
  logic [NUM_CH-1:0] clr_q;

  assign cur_oh = NUM_CH'(1) << cur_ch;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    dma2ch_chan #(.AW(AW), .CNT_W(CNT_W)) u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (start_i[g]),
      .src_i   (cfg_src_i[g]),
      .dst_i   (cfg_dst_i[g]),
      .cnt_i   (cfg_cnt_i[g]),
      .size_i  (cfg_size_i[g]),
      .ext_i   (cfg_ext_i[g]),
      .burst_i (cfg_burst_i[g]),
      .sw_req_i(sw_req_i[g]),
      .dreq_i  (dreq_i[g]),
      .step_i  (step && cur_oh[g]),
      .elig_o  (elig[g]),
      .src_o   (ch_src[g]),
      .dst_o   (ch_dst[g]),
      .size_o  (ch_size[g]),
      .ext_o   (ch_ext[g]),
      .burst_o (ch_burst[g]),
      .last_o  (ch_last[g]),
      .done_o  (ch_done[g]),
      .err_o   (ch_err[g])
    );
  end

  dma2ch_arb #(.IW(IW)) u_arb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rr_i    (rr_mode_i),
    .req_i   (elig),
    .upd_i   (step),
    .served_i(cur_ch),
    .pick_o  (pick),
    .any_o   (any_req)
  );

  dma2ch_xfer #(.AW(AW), .DW(DW), .IW(IW)) u_xfer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .any_i      (any_req),
    .pick_i     (pick),
    .src_i      (ch_src[cur_ch]),
    .dst_i      (ch_dst[cur_ch]),
    .size_i     (ch_size[cur_ch]),
    .burst_i    (ch_burst[cur_ch]),
    .last_i     (ch_last[cur_ch]),
    .bus_gnt_i  (bus_gnt_i),
    .rdata_i    (mem_rdata_i),
    .ack_i      (mem_ack_i),
    .cur_ch_o   (cur_ch),
    .step_o     (step),
    .bus_req_o  (bus_req_o),
    .mem_req_o  (mem_req_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .mem_size_o (mem_size_o),
    .mem_wdata_o(mem_wdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) clr_q <= '0;
    else         clr_q <= step ? (ch_ext & cur_oh) : '0;
  end

  assign dreq_clr_o = clr_q;
  assign tc_o       = mem_req_o ? (ch_last & cur_oh) : '0;
  assign irq_done_o = ch_done & ~irq_mask_i;
  assign irq_err_o  = ch_err & ~irq_mask_i;
endmodule

// File: rtl/dma2ch_chk.sv
module dma2ch_chk
  import dma2ch_pkg::*;
#(
  parameter int AW = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_req_i,
  input logic              mem_req_i,
  input logic              mem_we_i,
  input logic              mem_ack_i,
  input logic [AW-1:0]     mem_addr_i,
  input logic [NUM_CH-1:0] tc_i,
  input logic [NUM_CH-1:0] dreq_clr_i
);
  AST_ACCESS_NEEDS_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i |-> bus_req_i); // R5

  AST_READ_THEN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_i && !mem_we_i && mem_ack_i) |=> (mem_req_i && mem_we_i)); // R2

  AST_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_i && !mem_ack_i) |=> (mem_req_i && $stable(mem_addr_i))); // R2

  AST_TC_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(tc_i)); // R11

  AST_TC_IN_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_i != '0) |-> mem_req_i); // R11

  AST_CLR_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dreq_clr_i != '0) |=> (dreq_clr_i == '0)); // R10

  AST_CLR_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(|dreq_clr_i) |-> $past(mem_req_i && mem_we_i && mem_ack_i)); // R10
endmodule

bind dma2ch dma2ch_chk #(.AW(AW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .bus_req_i (bus_req_o),
  .mem_req_i (mem_req_o),
  .mem_we_i  (mem_we_o),
  .mem_ack_i (mem_ack_i),
  .mem_addr_i(mem_addr_o),
  .tc_i      (tc_o),
  .dreq_clr_i(dreq_clr_o)
);

// File: tb/dma2ch_test.sv
module dma2ch_test;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 4;

  typedef struct {
    logic [31:0] a;
    logic [31:0] d;
    logic [1:0]  s;
    logic [1:0]  tc;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rr_mode;
  logic [1:0] start, ext, burst, sw_req, mask, dreq;
  logic [1:0][31:0] src, dst;
  logic [1:0][CW-1:0] cnt;
  logic [1:0][1:0] size;
  logic [1:0] dreq_clr, tc, irq_done, irq_err;
  logic bus_req, bus_gnt, mem_req, mem_we, mem_ack;
  logic [1:0] mem_size;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  int checks = 0, errs = 0, rises = 0, wr_cnt = 0;
  bit bus_req_prev = 1'b0;
  bit finished = 1'b0;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma2ch #(.AW(32), .DW(32), .CNT_W(CW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .rr_mode_i(rr_mode), .start_i(start),
    .cfg_src_i(src), .cfg_dst_i(dst), .cfg_cnt_i(cnt), .cfg_size_i(size),
    .cfg_ext_i(ext), .cfg_burst_i(burst), .sw_req_i(sw_req), .irq_mask_i(mask),
    .dreq_i(dreq), .dreq_clr_o(dreq_clr), .tc_o(tc), .irq_done_o(irq_done),
    .irq_err_o(irq_err), .bus_req_o(bus_req), .bus_gnt_i(bus_gnt),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_size_o(mem_size),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .mem_ack_i(mem_ack)
  );

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[15:0] ^ 16'hC3A5, a[15:0]};
  endfunction

  // bus and memory responder: grant one cycle after request, ack every other cycle
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_gnt   <= 1'b0;
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
    end else begin
      bus_gnt   <= bus_req;
      mem_ack   <= mem_req && !mem_ack;
      mem_rdata <= pat(mem_addr);
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // reference comparison on every clock
  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_req && !bus_req_prev) rises++;
      bus_req_prev = bus_req;
      if (mem_req && mem_we && mem_ack) begin
        wr_cnt++;
        if (exp_q.size() == 0) begin
          chk("R2 unexpected write", mem_addr, 32'hFFFF_FFFF);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk("R3 write address", mem_addr, e.a);
          chk("R2 write data", mem_wdata, e.d);
          chk("R2 size code", {30'd0, mem_size}, {30'd0, e.s});
          chk("R11 terminal count", {30'd0, tc}, {30'd0, e.tc});
        end
      end
    end else begin
      bus_req_prev = 1'b0;
    end
  end

  task automatic push_one(input logic [31:0] s, input logic [31:0] d,
                          input logic [1:0] sz, input logic [1:0] tcv);
    exp_t e;
    e.a = d; e.d = pat(s); e.s = sz; e.tc = tcv;
    exp_q.push_back(e);
  endtask

  task automatic expect_op(input int ch, input logic [31:0] s, input logic [31:0] d,
                           input int n, input logic [1:0] sz);
    int total;
    int inc;
    total = (n == 0) ? (1 << CW) : n;
    inc = 1 << sz;
    for (int k = 0; k < total; k++)
      push_one(s + k*inc, d + k*inc, sz, (k == total-1) ? 2'(1 << ch) : 2'b00);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    rr_mode = 1'b0; start = '0; ext = '0; burst = '0; sw_req = '0;
    mask = '0; dreq = '0; src = '0; dst = '0; cnt = '0; size = '0;
    exp_q.delete();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic set_ch(input int ch, input logic [31:0] s, input logic [31:0] d,
                        input int n, input logic [1:0] sz, input bit e, input bit b);
    src[ch] = s; dst[ch] = d; cnt[ch] = CW'(n); size[ch] = sz;
    ext[ch] = e; burst[ch] = b;
  endtask

  task automatic pulse_start(input logic [1:0] which);
    @(negedge clk) start = which;
    @(negedge clk) start = '0;
  endtask

  task automatic pulse_sw(input logic [1:0] which);
    @(negedge clk) sw_req = which;
    @(negedge clk) sw_req = '0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_clr0();
    do @(negedge clk); while (!dreq_clr[0]);
    dreq[0] = 1'b0;
  endtask

  initial begin
    int r0, w0;
    do_reset();
    // R1 reset state
    chk("R1 bus_req", {31'd0, bus_req}, 32'd0);
    chk("R1 mem_req", {31'd0, mem_req}, 32'd0);
    chk("R1 tc/clr/irq", {24'd0, tc, dreq_clr, irq_done, irq_err}, 32'd0);

    // R9 unarmed trigger ignored, then R5 cycle steal, R3 word steps
    r0 = rises; w0 = wr_cnt;
    pulse_sw(2'b01);
    set_ch(0, 32'h100, 32'h1000, 3, 2'd2, 1'b0, 1'b0);
    pulse_start(2'b01);
    repeat (6) @(negedge clk);
    chk("R9 no bus before trigger", rises - r0, 0);
    expect_op(0, 32'h100, 32'h1000, 3, 2'd2);
    pulse_sw(2'b01);
    drain();
    chk("R5 one bus request per transfer", rises - r0, 3);
    chk("R4 count 3", wr_cnt - w0, 3);
    chk("R12 done irq", {30'd0, irq_done}, 32'd1);

    // R6 burst, half-word, masked done irq
    do_reset();
    mask = 2'b10;
    r0 = rises;
    set_ch(1, 32'h202, 32'h2002, 4, 2'd1, 1'b0, 1'b1);
    pulse_start(2'b10);
    expect_op(1, 32'h202, 32'h2002, 4, 2'd1);
    pulse_sw(2'b10);
    drain();
    chk("R6 single bus request in burst", rises - r0, 1);
    chk("R12 masked done", {30'd0, irq_done}, 32'd0);
    mask = 2'b00;
    @(negedge clk);
    chk("R12 unmasked done", {30'd0, irq_done}, 32'd2);

    // R4 count 0 means full range, byte size, burst
    do_reset();
    w0 = wr_cnt;
    set_ch(0, 32'h301, 32'h1101, 0, 2'd0, 1'b0, 1'b1);
    pulse_start(2'b01);
    expect_op(0, 32'h301, 32'h1101, 0, 2'd0);
    pulse_sw(2'b01);
    drain();
    chk("R4 count zero", wr_cnt - w0, 1 << CW);

    // R7 fixed priority with simultaneous requests
    do_reset();
    set_ch(0, 32'h100, 32'h1000, 2, 2'd2, 1'b0, 1'b0);
    set_ch(1, 32'h200, 32'h2000, 2, 2'd2, 1'b0, 1'b0);
    pulse_start(2'b11);
    push_one(32'h100, 32'h1000, 2'd2, 2'b00);
    push_one(32'h104, 32'h1004, 2'd2, 2'b01);
    push_one(32'h200, 32'h2000, 2'd2, 2'b00);
    push_one(32'h204, 32'h2004, 2'd2, 2'b10);
    pulse_sw(2'b11);
    drain();
    chk("R7 fixed order done", {30'd0, irq_done}, 32'd3);

    // R8 round robin with simultaneous requests
    do_reset();
    rr_mode = 1'b1;
    set_ch(0, 32'h100, 32'h1000, 2, 2'd2, 1'b0, 1'b0);
    set_ch(1, 32'h200, 32'h2000, 2, 2'd2, 1'b0, 1'b0);
    pulse_start(2'b11);
    push_one(32'h100, 32'h1000, 2'd2, 2'b00);
    push_one(32'h200, 32'h2000, 2'd2, 2'b00);
    push_one(32'h104, 32'h1004, 2'd2, 2'b01);
    push_one(32'h204, 32'h2004, 2'd2, 2'b10);
    pulse_sw(2'b11);
    drain();
    chk("R8 round robin done", {30'd0, irq_done}, 32'd3);

    // R10 external request handshake
    do_reset();
    w0 = wr_cnt;
    set_ch(0, 32'h400, 32'h1200, 2, 2'd2, 1'b1, 1'b0);
    pulse_start(2'b01);
    expect_op(0, 32'h400, 32'h1200, 2, 2'd2);
    repeat (4) @(negedge clk);
    chk("R10 idle without request", wr_cnt - w0, 0);
    dreq[0] = 1'b1;
    wait_clr0();
    chk("R10 one transfer per request", wr_cnt - w0, 1);
    @(negedge clk);
    chk("R10 clear is one cycle", {30'd0, dreq_clr}, 32'd0);
    repeat (8) @(negedge clk);
    chk("R10 no transfer while request low", wr_cnt - w0, 1);
    dreq[0] = 1'b1;
    wait_clr0();
    drain();
    chk("R10 second transfer", wr_cnt - w0, 2);
    chk("R12 ext done", {30'd0, irq_done}, 32'd1);

    // R13 misalignment and reserved size
    do_reset();
    r0 = rises;
    set_ch(1, 32'h102, 32'h2000, 2, 2'd2, 1'b0, 1'b0);
    set_ch(0, 32'h100, 32'h1000, 2, 2'd3, 1'b0, 1'b0);
    pulse_start(2'b11);
    pulse_sw(2'b11);
    repeat (6) @(negedge clk);
    chk("R13 error flags", {30'd0, irq_err}, 32'd3);
    chk("R13 no bus activity", rises - r0, 0);
    mask = 2'b01;
    @(negedge clk);
    chk("R12 masked error", {30'd0, irq_err}, 32'd2);
    set_ch(1, 32'h100, 32'h2000, 1, 2'd2, 1'b0, 1'b0);
    pulse_start(2'b10);
    chk("R12 start clears error", {30'd0, irq_err}, 32'd0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errs++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
    end
  end
endmodule